// File: doc/BRIEF.md
# Ratio Clock Domain Bus Bridge

This block moves bus data between a slow bus clock and a fast core clock whose frequency is an integer multiple of it. Both clocks come from one source and their edges line up at every slow boundary. No synchronizer chains are used. The block relies on an end-of-cycle strobe that the clock source provides in the fast domain. The strobe is high in the last fast cycle of every slow cycle. Registers that cross domains load only at the fast edge that closes such a cycle. Every cross-domain path therefore gets a full slow period, which is RATIO fast cycles, to settle.

Inbound, a slow-domain register samples the bus. A fast-domain register takes that value at the next strobed boundary. Outbound, a fast-domain hold stage samples the core's value at a strobed boundary and keeps it for the whole next slow cycle. A slow-domain register then takes the held value, but only if the core's access-enable was high when it was sampled. Two level signals, one running toward the core and one away from it, each pass through a single fast-cycle register.

Top module: `ratio_bus_bridge`

## Requirements
- R1: While rst_ni is low, in_data_o, out_data_o, lvl_core_o and lvl_ctrl_o are all zero.
- R2: A value on in_data_i that the slow clock samples at boundary k appears on in_data_o at boundary k+1, provided eoc_i was high in the fast cycle that closes slow cycle k+1.
- R3: in_data_o changes only at fast edges where eoc_i is high. It stays constant through each slow cycle, and it keeps its old value across a boundary where eoc_i was low.
- R4: The outbound hold stage samples out_data_i only at a fast edge where eoc_i is high. Values that out_data_i takes in the other fast cycles have no effect on out_data_o.
- R5: At the slow edge after a strobed sample, out_data_o takes the held value if acc_en_i was 1 at the sample, and keeps its old value otherwise.
- R6: acc_en_i changes only in the fast cycle that directly follows a cycle with eoc_i high, which is the first fast cycle of a slow cycle.
- R7: eoc_i is never high in two consecutive fast cycles.
- R8: lvl_core_o equals lvl_core_i from one fast cycle earlier, and lvl_ctrl_o equals lvl_ctrl_i from one fast cycle earlier.
- R9: RATIO is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast core clock |
| clk_slow_i | input | 1 | Slow bus clock, edge-aligned, RATIO times slower |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| eoc_i | input | 1 | End-of-slow-cycle strobe, fast domain |
| acc_en_i | input | 1 | Core bus access enable, fast domain |
| in_data_i | input | DATA_W | Bus data toward the core, slow domain |
| in_data_o | output | DATA_W | Captured inbound data, fast domain |
| out_data_i | input | DATA_W | Core data toward the bus, fast domain |
| out_data_o | output | DATA_W | Outbound data, slow domain |
| lvl_core_i | input | LVL_W | Level lines toward the core |
| lvl_core_o | output | LVL_W | Registered level lines toward the core |
| lvl_ctrl_i | input | LVL_W | Level lines from the core |
| lvl_ctrl_o | output | LVL_W | Registered level lines from the core |

## Verification
The assertions take three things for granted. The strobe is a single-cycle pulse. acc_en_i moves only in the fast cycle after a strobe. The slow clock rises at the same instant as the fast edge that closes each strobed cycle. The stimulus meets all three. One process produces both clocks from a single phase counter. The strobe is driven only in the phase just before a slow edge, and it is randomly left out at some boundaries. acc_en_i is redrawn only at the start of a slow cycle whose opening boundary was strobed. out_data_i gets random junk in the non-strobe fast cycles so that only the strobed value should count.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_LVL_W  = 15;
  localparam int unsigned DEF_RATIO  = 4;
  localparam int unsigned MIN_RATIO  = 2;
endpackage

// File: rtl/rcb_lvl_reg.sv
module rcb_lvl_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rcb_in_path.sv
module rcb_in_path #(
  parameter int unsigned W = 32
) (
  input  logic         clk_fast_i,
  input  logic         clk_slow_i,
  input  logic         rst_ni,
  input  logic         eoc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] slow_q;
  logic [W-1:0] fast_q;

  always_ff @(posedge clk_slow_i or negedge rst_ni) begin
    if (!rst_ni) slow_q <= '0;
    else         slow_q <= data_i;
  end

  // multicycle path: slow_q -> fast_q, valid only at strobed edge
  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni)    fast_q <= '0;
    else if (eoc_i) fast_q <= slow_q;
  end

  assign data_o = fast_q;

  p_in_hold_r3: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    !$past(eoc_i) |-> $stable(fast_q))
    else $error("R3: inbound capture changed without strobe");
endmodule

// File: rtl/rcb_out_path.sv
module rcb_out_path #(
  parameter int unsigned W = 32
) (
  input  logic         clk_fast_i,
  input  logic         clk_slow_i,
  input  logic         rst_ni,
  input  logic         eoc_i,
  input  logic         acc_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] hold_q;
  logic         hold_en_q;
  logic [W-1:0] slow_q;

  // sampled at a boundary, stable for the whole next slow cycle
  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      hold_en_q <= 1'b0;
    end else if (eoc_i) begin
      hold_q    <= data_i;
      hold_en_q <= acc_en_i;
    end
  end

  // multicycle path: hold stage -> slow_q
  always_ff @(posedge clk_slow_i or negedge rst_ni) begin
    if (!rst_ni)        slow_q <= '0;
    else if (hold_en_q) slow_q <= hold_q;
  end

  assign data_o = slow_q;

  p_hold_stable_r4: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    !$past(eoc_i) |-> ($stable(hold_q) && $stable(hold_en_q)))
    else $error("R4: hold stage moved without strobe");

  p_out_gate_r5: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    !$past(hold_en_q) |-> $stable(slow_q))
    else $error("R5: outbound register moved without access enable");
endmodule

// File: rtl/ratio_bus_bridge.sv
module ratio_bus_bridge
  import rcb_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LVL_W  = DEF_LVL_W,
  parameter int unsigned RATIO  = DEF_RATIO
) (
  input  logic              clk_fast_i,
  input  logic              clk_slow_i,
  input  logic              rst_ni,
  input  logic              eoc_i,
  input  logic              acc_en_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] in_data_o,
  input  logic [DATA_W-1:0] out_data_i,
  output logic [DATA_W-1:0] out_data_o,
  input  logic [LVL_W-1:0]  lvl_core_i,
  output logic [LVL_W-1:0]  lvl_core_o,
  input  logic [LVL_W-1:0]  lvl_ctrl_i,
  output logic [LVL_W-1:0]  lvl_ctrl_o
);
  localparam int unsigned NLVL = 2;

  logic [NLVL-1:0][LVL_W-1:0] lvl_d;
  logic [NLVL-1:0][LVL_W-1:0] lvl_q;

  rcb_in_path #(.W(DATA_W)) u_in (
    .clk_fast_i (clk_fast_i),
    .clk_slow_i (clk_slow_i),
    .rst_ni     (rst_ni),
    .eoc_i      (eoc_i),
    .data_i     (in_data_i),
    .data_o     (in_data_o)
  );

  rcb_out_path #(.W(DATA_W)) u_out (
    .clk_fast_i (clk_fast_i),
    .clk_slow_i (clk_slow_i),
    .rst_ni     (rst_ni),
    .eoc_i      (eoc_i),
    .acc_en_i   (acc_en_i),
    .data_i     (out_data_i),
    .data_o     (out_data_o)
  );

  assign lvl_d[0] = lvl_core_i;
  assign lvl_d[1] = lvl_ctrl_i;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    rcb_lvl_reg #(.W(LVL_W)) u_lvl (
      .clk_i  (clk_fast_i),
      .rst_ni (rst_ni),
      .d_i    (lvl_d[g]),
      .q_o    (lvl_q[g])
    );
  end

  assign lvl_core_o = lvl_q[0];
  assign lvl_ctrl_o = lvl_q[1];

  initial p_ratio_r9: assert (RATIO >= MIN_RATIO)
    else $error("R9: clock ratio below minimum");

  p_acc_align_r6: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (acc_en_i != $past(acc_en_i)) |-> $past(eoc_i))
    else $error("R6: access enable moved off boundary");

  p_eoc_pulse_r7: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    eoc_i |=> !eoc_i)
    else $error("R7: strobe longer than one fast cycle");
endmodule

// File: tb/sim_ratio_bus_bridge.sv
module sim_ratio_bus_bridge;
  localparam int DW = 16, LW = 4, RATIO = 4, NCYC = 300;

  logic clk_f, clk_s, rst_n, eoc, acc_en;
  logic [DW-1:0] in_d, in_q, out_d, out_q;
  logic [LW-1:0] lc_i, lc_o, lt_i, lt_o;
  int ph, n_chk, n_bad;
  bit done;

  ratio_bus_bridge #(.DATA_W(DW), .LVL_W(LW), .RATIO(RATIO)) u0 (
    .clk_fast_i(clk_f), .clk_slow_i(clk_s), .rst_ni(rst_n), .eoc_i(eoc),
    .acc_en_i(acc_en), .in_data_i(in_d), .in_data_o(in_q),
    .out_data_i(out_d), .out_data_o(out_q),
    .lvl_core_i(lc_i), .lvl_core_o(lc_o), .lvl_ctrl_i(lt_i), .lvl_ctrl_o(lt_o));

  // both clocks from one process: edges coincide at slow boundaries
  initial begin
    clk_f = 0; clk_s = 0; ph = 0;
    forever begin
      #2 clk_f = 1;
      if (ph == 0) clk_s = 1;
      else if (ph == RATIO/2) clk_s = 0;
      ph = (ph == RATIO-1) ? 0 : ph + 1;
      #2 clk_f = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nxt_out(logic en, logic [DW-1:0] h, logic [DW-1:0] o);
    return en ? h : o;  // R5
  endfunction

  initial begin
    logic [DW-1:0] m_in_slow, m_in_fast, m_hold, m_out, pa, pb, a, b;
    logic m_hold_en, pe, pq, e, q;
    int seed;
    seed = $urandom(32'h5eed);
    rst_n = 0; eoc = 0; acc_en = 0; in_d = '1; out_d = '1;
    repeat (6) @(negedge clk_f);
    chk("R1 in", 32'(in_q), 0);
    chk("R1 out", 32'(out_q), 0);
    chk("R1 lvl", {lc_o, lt_o}, 0);
    in_d = 0; out_d = 0;
    while (ph != 1) @(negedge clk_f);
    rst_n = 1;
    m_in_slow = 0; m_in_fast = 0; m_hold = 0; m_hold_en = 0; m_out = 0;
    pa = 0; pb = 0; pe = 0; pq = 0; e = 0;
    for (int k = 0; k < NCYC; k++) begin
      if (k > 0) begin
        m_out = nxt_out(m_hold_en, m_hold, m_out);
        if (pq) begin
          m_in_fast = m_in_slow; m_hold = pb; m_hold_en = pe;
        end
        m_in_slow = pa;
      end
      chk(pq ? "R2" : "R3", 32'(in_q), 32'(m_in_fast));
      chk(m_hold_en ? "R4" : "R5", 32'(out_q), 32'(m_out));
      a = (k == 5) ? '1 : DW'($urandom);
      b = (k == 5) ? '1 : DW'($urandom);
      if (pq) e = (k < 8) ? k[1] : ($urandom_range(0, 2) != 0);  // R6 alignment
      q = (k % 11 == 4) || (k % 11 == 5) ? 1'b0 : ($urandom_range(0, 5) != 0);
      in_d = a; acc_en = e; out_d = DW'($urandom);
      do begin
        @(negedge clk_f);
        if (ph != 0) out_d = DW'($urandom);
      end while (ph != 0);
      chk("R3 mid", 32'(in_q), 32'(m_in_fast));
      out_d = b; eoc = q;
      @(negedge clk_f);
      eoc = 0; out_d = DW'($urandom);
      pa = a; pb = b; pe = e; pq = q;
    end
    done = 1;
    @(negedge clk_f);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] pc, pt;
    lc_i = 0; lt_i = 0; pc = 0; pt = 0;
    @(posedge rst_n);
    while (!done) begin
      @(negedge clk_f);
      chk("R8 core", 32'(lc_o), 32'(pc));
      chk("R8 ctrl", 32'(lt_o), 32'(pt));
      pc = LW'($urandom); pt = LW'($urandom);
      lc_i = pc; lt_i = pt;
    end
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule